// File: doc/BRIEF.md
# Fast PWM DAC Channel Bank

This block drives five pulse-width-modulated outputs that an external RC network turns into analog levels. All channels share one free-running period counter, advanced by a tick enable derived from the clock. Each channel compares the counter with its own 8-bit duty code. A small register port holds the duty codes, a per-pin enable mask and a two-bit mode word. One mode bit doubles the PWM rate. The other shortens the period from 256 to 253 steps, and in that short mode the top three codes hold the output steadily high.

Each output pin either carries its channel's waveform or passes through a general-purpose port bit, as chosen by that channel's enable bit. A duty code written by software is held in a staging register. It moves to the comparator only when a period ends, so the output never shows a truncated or doubled pulse.

Top module: `pwm_dac_bank`

## Requirements
- R1: Register addresses 0 to 4 hold the duty codes of channels 0 to 4. They read back the written value, and each resets to 80h.
- R2: After reset the enable mask and the mode word read 0, and every pin shows its port bit.
- R3: Mode bit 0 selects the rate. When it is 1 the counter advances every TICK_DIV clocks, and when it is 0 it advances every 2*TICK_DIV clocks.
- R4: Mode bit 1 selects the period length: 256 counter steps when it is 0 and 253 steps when it is 1. A change takes effect at the next period boundary.
- R5: In 253-step mode, duty codes FDh, FEh and FFh give a constant high output.
- R6: Duty code 00h gives a constant low output in both step modes.
- R7: A duty code D keeps the output high for D counter steps per period. This holds for every code in 256-step mode, and for codes 1 to 252 in 253-step mode.
- R8: A newly written duty code takes effect only at the start of the next period. The period that is running when the write occurs finishes with the old code.
- R9: Address 5 is the enable mask, with bit c for channel c. When bit c is 1, pin c carries the PWM output and ignores port bit c. When it is 0, pin c shows port bit c.
- R10: Address 6 is the mode word. Only bits 1:0 are stored, and the unused bits of the mask and mode registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| port_in | input | 5 | General-purpose port bits for pass-through |
| pin_out | output | 5 | Output pins |

## Verification
The assertions place no limits on when software writes. They assume only that the mode word can change at any clock, and that TICK_DIV is at least 1, so the slow rate always leaves a gap between ticks. Because mode and duty changes can land in the middle of a period, the properties hold for arbitrary write timing, not just for writes aligned to period boundaries. The stimulus uses single-cycle write strobes driven at the falling edge, and addresses within the seven-entry map. It measures high time over windows exactly one period long, after waiting out the period in which a write lands.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;
  localparam int          DUTY_W       = 8;
  localparam logic [7:0]  DUTY_RESET   = 8'h80;
  localparam logic [7:0]  FORCE_HI_MIN = 8'hFD;
  localparam logic [7:0]  LAST_LONG    = 8'd255;
  localparam logic [7:0]  LAST_SHORT   = 8'd252;

  typedef struct packed {
    logic short_per;  // bit 1: 253-step period
    logic fast;       // bit 0: double rate
  } mode_t;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int TICK_DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast,
  output logic tick
);
  localparam int PW = $clog2(2 * TICK_DIV) + 1;

  logic [PW-1:0] pre_q, pre_d, div_last;

  always_comb begin
    div_last = fast ? PW'(TICK_DIV - 1) : PW'(2 * TICK_DIV - 1);
    tick     = (pre_q >= div_last);
    pre_d    = tick ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // At the slow rate two ticks never fall on adjacent clocks
  assert_slow_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast && tick) |=> (!tick || fast))
    else $error("slow rate ticked on consecutive clocks");
endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr
  import pwm_dac_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       short_act,
  output logic [7:0] cnt_q,
  output logic       wrap
);
  logic [7:0] last, cnt_d;

  always_comb begin
    last  = short_act ? LAST_SHORT : LAST_LONG;
    wrap  = tick && (cnt_q >= last);
    if (wrap)      cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 8'd1;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // In the short period the count never passes the last short step
  assert_short_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    short_act |-> (cnt_q <= LAST_SHORT))
    else $error("counter beyond short period");
endmodule

// File: rtl/pwm_dac_chan.sv
module pwm_dac_chan
  import pwm_dac_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrap,
  input  logic       short_act,
  input  logic [7:0] cnt,
  input  logic [7:0] duty_stage,
  output logic       pwm_q
);
  logic [7:0] duty_act_q, duty_act_d;
  logic       pwm_d;

  always_comb begin
    duty_act_d = wrap ? duty_stage : duty_act_q;
    if (short_act && (duty_act_q >= FORCE_HI_MIN)) pwm_d = 1'b1;
    else                                           pwm_d = (cnt < duty_act_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_act_q <= DUTY_RESET;
      pwm_q      <= 1'b0;
    end else begin
      duty_act_q <= duty_act_d;
      pwm_q      <= pwm_d;
    end
  end

  assert_force_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (short_act && duty_act_q >= FORCE_HI_MIN) |=> pwm_q)
    else $error("forced-high code produced a low output");

  assert_zero_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act_q == 8'h00) |=> !pwm_q)
    else $error("zero code produced a high output");

  assert_duty_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(duty_act_q))
    else $error("active duty changed inside a period");
endmodule

// File: rtl/pwm_dac_bank.sv
module pwm_dac_bank
  import pwm_dac_pkg::*;
#(
  parameter int N_CH     = 5,
  parameter int TICK_DIV = 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             reg_we,
  input  logic [$clog2(N_CH + 2)-1:0]      reg_addr,
  input  logic [7:0]                       reg_wdata,
  output logic [7:0]                       reg_rdata,
  input  logic [N_CH-1:0]                  port_in,
  output logic [N_CH-1:0]                  pin_out
);
  localparam int AW        = $clog2(N_CH + 2);
  localparam int ADDR_MASK = N_CH;
  localparam int ADDR_MODE = N_CH + 1;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [7:0]      duty_q [N_CH];
  logic [7:0]      duty_d [N_CH];
  logic [N_CH-1:0] mask_q, mask_d;
  mode_t           mode_q, mode_d;
  logic            short_act_q, short_act_d;
  logic            tick, wrap;
  logic [7:0]      cnt;
  logic [N_CH-1:0] pwm;

  always_comb begin
    for (int c = 0; c < N_CH; c++) duty_d[c] = duty_q[c];
    mask_d = mask_q;
    mode_d = mode_q;
    if (reg_we) begin
      for (int c = 0; c < N_CH; c++)
        if (reg_addr == AW'(c)) duty_d[c] = reg_wdata;
      if (reg_addr == AW'(ADDR_MASK)) mask_d = reg_wdata[N_CH-1:0];
      if (reg_addr == AW'(ADDR_MODE)) mode_d = mode_t'(reg_wdata[1:0]);
    end
    short_act_d = wrap ? mode_q.short_per : short_act_q;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      for (int c = 0; c < N_CH; c++) duty_q[c] <= DUTY_RESET;
      mask_q      <= '0;
      mode_q      <= '0;
      short_act_q <= 1'b0;
    end else begin
      for (int c = 0; c < N_CH; c++) duty_q[c] <= duty_d[c];
      mask_q      <= mask_d;
      mode_q      <= mode_d;
      short_act_q <= short_act_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < N_CH; c++)
      if (reg_addr == AW'(c)) reg_rdata = duty_q[c];
    if (reg_addr == AW'(ADDR_MASK)) reg_rdata[N_CH-1:0] = mask_q;
    if (reg_addr == AW'(ADDR_MODE)) reg_rdata[1:0] = mode_q;
  end

  pwm_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_sync_q), .fast(mode_q.fast), .tick(tick)
  );

  pwm_period_ctr u_ctr (
    .clk(clk), .rst_n(rst_sync_q), .tick(tick), .short_act(short_act_q),
    .cnt_q(cnt), .wrap(wrap)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    pwm_dac_chan u_chan (
      .clk(clk), .rst_n(rst_sync_q), .wrap(wrap), .short_act(short_act_q),
      .cnt(cnt), .duty_stage(duty_q[c]), .pwm_q(pwm[c])
    );
    assign pin_out[c] = mask_q[c] ? pwm[c] : port_in[c];
  end
endmodule

// File: tb/pwm_dac_bank_bench.sv
module pwm_dac_bank_bench;
  localparam int N = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_we;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [N-1:0] port_in;
  logic [N-1:0] pin_out;

  int errors = 0;
  int checks = 0;
  int hc [N];
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_dac_bank #(.N_CH(N), .TICK_DIV(1)) u_pwm_dac_bank (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .port_in(port_in), .pin_out(pin_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_addr = 3'(a);
    #1 d = int'(reg_rdata);
  endtask

  task automatic measure(input int p);
    for (int c = 0; c < N; c++) hc[c] = 0;
    for (int i = 0; i < p; i++) begin
      @(negedge clk);
      for (int c = 0; c < N; c++) hc[c] += int'(pin_out[c]);
    end
  endtask

  function automatic int exp_hi(input int code, input bit shrt, input int cpt);
    int h;
    h = (shrt && code > 253) ? 253 : code;
    return h * cpt;
  endfunction

  // sweep codes in groups, one code per channel, for one mode setting
  task automatic sweep(input bit fast, input bit shrt, input int step_sz, input string tag);
    int cpt, p;
    cpt = fast ? 1 : 2;
    p   = (shrt ? 253 : 256) * cpt;
    wr(6, {6'b0, shrt, fast});
    for (int base = 0; base < 256; base += step_sz) begin
      for (int c = 0; c < N; c++) wr(c, (base + c * (step_sz / N + 1)) % 256);
      repeat (p + 8) @(negedge clk);
      measure(p);
      for (int c = 0; c < N; c++) begin
        int code;
        code = (base + c * (step_sz / N + 1)) % 256;
        chk(hc[c] == exp_hi(code, shrt, cpt), tag, hc[c], exp_hi(code, shrt, cpt));
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int d;
    bit prev;
    int h;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; port_in = 5'b01101;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1, R2, R9: reset values, pass-through with mask clear
    for (int c = 0; c < N; c++) begin
      rd(c, d);
      chk(d == 8'h80, "R1 duty reset", d, 8'h80);
    end
    rd(5, d); chk(d == 0, "R2 mask reset", d, 0);
    rd(6, d); chk(d == 0, "R2 mode reset", d, 0);
    chk(pin_out == port_in, "R2 pins follow port", int'(pin_out), int'(port_in));
    port_in = 5'b10010;
    #1 chk(pin_out == port_in, "R9 pass-through", int'(pin_out), int'(port_in));

    // R1 readback, R10 unused bits
    wr(3, 8'h5A); rd(3, d); chk(d == 8'h5A, "R1 readback", d, 8'h5A);
    wr(5, 8'hFF); rd(5, d); chk(d == 8'h1F, "R10 mask width", d, 8'h1F);
    wr(6, 8'hFF); rd(6, d); chk(d == 8'h03, "R10 mode width", d, 8'h03);
    wr(3, 8'h80);

    // R8: fast 256-step, channel 0 at 80h; write mid-period
    wr(6, 8'h01);
    repeat (600) @(negedge clk);
    prev = 1'b1;
    while (!(prev == 1'b0 && pin_out[0] == 1'b1)) begin
      prev = pin_out[0];
      @(negedge clk);
    end
    h = 0;
    for (int i = 0; i < 256; i++) begin
      h += int'(pin_out[0]);
      if (i == 10) begin reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h10; end
      else reg_we = 1'b0;
      @(negedge clk);
    end
    chk(h == 128, "R8 old duty finishes period", h, 128);
    h = 0;
    for (int i = 0; i < 256; i++) begin
      h += int'(pin_out[0]);
      @(negedge clk);
    end
    chk(h == 16, "R8 new duty next period", h, 16);

    // R7, R6: exhaustive fast 256-step sweep
    sweep(1'b1, 1'b0, 5, "R7 fast 256-step");
    // R4, R5, R6, R7: exhaustive fast 253-step sweep
    sweep(1'b1, 1'b1, 5, "R5 R7 fast 253-step");
    // R3: slow rate doubles every high time and period
    sweep(1'b0, 1'b0, 64, "R3 slow 256-step");
    sweep(1'b0, 1'b1, 64, "R3 slow 253-step");

    // R5 and R6 corner codes in 253-step fast mode
    wr(6, 8'h03);
    wr(0, 8'hFD); wr(1, 8'hFE); wr(2, 8'hFF); wr(3, 8'h00); wr(4, 8'hFC);
    repeat (300) @(negedge clk);
    measure(253);
    chk(hc[0] == 253, "R5 FD high", hc[0], 253);
    chk(hc[1] == 253, "R5 FE high", hc[1], 253);
    chk(hc[2] == 253, "R5 FF high", hc[2], 253);
    chk(hc[3] == 0,   "R6 00 low",  hc[3], 0);
    chk(hc[4] == 252, "R7 FC",      hc[4], 252);

    // R9: partial mask, enabled pins ignore port, others follow it
    wr(0, 8'h00); wr(2, 8'h00);
    wr(5, 8'h05);
    repeat (300) @(negedge clk);
    port_in = 5'b11111;
    #1 chk(pin_out == 5'b11010, "R9 mask mix high port", int'(pin_out), 5'b11010);
    port_in = 5'b00000;
    @(negedge clk);
    chk(pin_out == 5'b00000, "R9 mask mix low port", int'(pin_out), 0);
    wr(0, 8'hFF);
    repeat (300) @(negedge clk);
    chk(pin_out == 5'b00001, "R9 enabled pin ignores port", int'(pin_out), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule